// File: doc/BRIEF.md
# Cache-Control Operation Sequencer

This block executes decoded cache-maintenance, barrier and TLB-synchronization operations one at a time. For each operation it gets the operation code, the target line address, the line's present coherence state and a global address-broadcast enable. From these it works out which transaction, if any, goes out on the system bus. It also works out the state the line must take afterwards, whether the second-level cache is told, and whether completion has to wait for an external condition.

It has four ports. The bus port carries a request held until acknowledged. The second-level cache port carries a one-cycle notice. The tag store port carries a one-cycle state write. The fourth port watches snooped transactions from other masters. A snooped kill-block invalidates the addressed line and takes priority over the local operation's own tag write. A ready/busy pair keeps a single operation in flight.

Top module: `cop_seq`

## Requirements
- R1: `op_ready` is high exactly when `busy` is low. An operation is taken on a cycle with `op_valid` and `op_ready` both high. `busy` rises in the next cycle and stays high until every bus acknowledge, wait condition and tag write of that operation has completed. Codes on `op_code`: 0 memory sync, 1 TLB invalidate, 2 TLB sync, 3 I/O ordering barrier, 4 instruction-cache invalidate, 5 data invalidate, 6 data flush, 7 data clean, 8 data zero, 9 touch, 10 touch-for-store. Codes 11 to 15 complete with no effect. States on `op_state` and `tag_state`: 0 Invalid, 1 Exclusive, 2 Modified, with 3 read as Invalid. Kinds on `bus_kind` and `snp_kind`: 1 sync, 2 I/O order, 3 kill-block, 4 flush, 5 clean, 6 write-with-kill, 7 read-with-intent-to-modify.
- R2: Data zero on an Exclusive or Modified line issues kill-block whatever `bcast_en` says. On an Invalid line it issues write-with-kill. In every case it writes Modified to the tag store.
- R3: Data invalidate, flush and clean send their address-only kinds (3, 4, 5) only when `bcast_en` is 1. With `bcast_en` at 0 they issue nothing on the bus.
- R4: Flush of a Modified line issues write-with-kill. Flush writes Invalid to the tag store from any state.
- R5: Clean of a Modified line issues write-with-kill and writes Exclusive. Clean of an Exclusive or Invalid line makes no tag write.
- R6: Data invalidate writes Invalid to the tag store from any state.
- R7: Instruction-cache invalidate and TLB invalidate produce no bus request, no tag write and no second-level notice, even with `bcast_en` at 1.
- R8: Touch and touch-for-store on an Invalid line issue read-with-intent-to-modify and write Exclusive. On an Exclusive or Modified line they produce nothing on any port.
- R9: Memory sync and the I/O barrier issue their kinds (1, 2) only when `bcast_en` is 1. Memory sync then stays busy until `memq_empty` is seen high.
- R10: TLB sync stays busy until `tlbsync_in` is seen low.
- R11: Data invalidate, flush, clean and zero pulse `l2_valid` for one cycle in the cycle after acceptance, carrying the op code and address, whatever `bcast_en` says.
- R12: A snooped transaction of kind 3 leads to a tag write of Invalid to `snp_addr` in the next cycle. Snooped transactions of any other kind are ignored. A snooped kill delays the local operation's tag write until a cycle with no snooped kill.
- R13: A bus request keeps `bus_kind` and `bus_addr` stable until the cycle in which `bus_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Block can take an operation |
| op_code | input | 4 | Operation code (R1) |
| op_addr | input | AW | Target line address |
| op_state | input | 2 | Current line coherence state |
| bcast_en | input | 1 | Global address-broadcast enable |
| busy | output | 1 | Operation in flight |
| bus_req | output | 1 | Bus transaction request |
| bus_kind | output | 3 | Bus transaction kind |
| bus_addr | output | AW | Bus transaction address |
| bus_ack | input | 1 | Bus acknowledge |
| memq_empty | input | 1 | Memory queues drained |
| tlbsync_in | input | 1 | External TLB-sync hold, high blocks completion |
| l2_valid | output | 1 | Second-level cache notice |
| l2_op | output | 4 | Operation code forwarded |
| l2_addr | output | AW | Address forwarded |
| tag_wr | output | 1 | Tag state write strobe |
| tag_addr | output | AW | Tag write address |
| tag_state | output | 2 | New line state |
| snp_valid | input | 1 | Snooped transaction present |
| snp_kind | input | 3 | Snooped transaction kind |
| snp_addr | input | AW | Snooped transaction address |

## Verification
A wrong decision in the decode shows up at the ports within one cycle of acceptance, as a missing, extra or mis-kinded bus request. A missing or extra second-level notice shows up in the cycle after acceptance. A wrong line state shows up on the tag write that ends the operation. A sequencer stuck in its waiting phase shows as `busy` held after `memq_empty` rises or `tlbsync_in` falls. Leaving that phase too early shows as `busy` dropping while the hold condition is still present. Broken snoop arbitration reorders tag writes or loses a write, and the first tag write after the snoop shows it.

// File: rtl/cop_pkg.sv
package cop_pkg;

    typedef enum logic [3:0] {
        OP_MEMSYNC  = 4'd0,
        OP_TLBINV   = 4'd1,
        OP_TLBSYNC  = 4'd2,
        OP_IOORDER  = 4'd3,
        OP_ICINV    = 4'd4,
        OP_DCINV    = 4'd5,
        OP_DCFLUSH  = 4'd6,
        OP_DCCLEAN  = 4'd7,
        OP_DCZERO   = 4'd8,
        OP_TOUCH    = 4'd9,
        OP_TOUCHST  = 4'd10
    } op_e;

    typedef enum logic [1:0] {
        CS_I = 2'd0,
        CS_E = 2'd1,
        CS_M = 2'd2
    } cstate_e;

    typedef enum logic [2:0] {
        BK_NONE  = 3'd0,
        BK_SYNC  = 3'd1,
        BK_IOORD = 3'd2,
        BK_KILL  = 3'd3,
        BK_FLUSH = 3'd4,
        BK_CLEAN = 3'd5,
        BK_WWK   = 3'd6,
        BK_RWITM = 3'd7
    } bus_e;

    typedef enum logic [1:0] {
        WT_NONE = 2'd0,
        WT_MEMQ = 2'd1,
        WT_TLB  = 2'd2
    } wait_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_BUS  = 2'd1,
        PH_WAIT = 2'd2,
        PH_FIN  = 2'd3
    } phase_e;

    typedef struct packed {
        bus_e    bus;
        logic    tag_wr;
        cstate_e tag_st;
        logic    l2;
        wait_e   wt;
    } plan_t;

endpackage

// File: rtl/cop_decode.sv
module cop_decode
    import cop_pkg::*;
(
    input  logic [3:0] code,
    input  logic [1:0] line_st,
    input  logic       bcast,
    output plan_t      plan
);
    logic hit;
    logic is_mod;

    always_comb begin
        is_mod = (line_st == CS_M);
        hit    = (line_st == CS_M) || (line_st == CS_E);
        plan   = '{bus: BK_NONE, tag_wr: 1'b0, tag_st: CS_I, l2: 1'b0, wt: WT_NONE};
        case (code)
            OP_MEMSYNC: begin
                plan.bus = bcast ? BK_SYNC : BK_NONE;
                plan.wt  = WT_MEMQ;
            end
            OP_IOORDER: plan.bus = bcast ? BK_IOORD : BK_NONE;
            OP_TLBSYNC: plan.wt  = WT_TLB;
            OP_DCINV: begin
                plan.bus    = bcast ? BK_KILL : BK_NONE;
                plan.tag_wr = 1'b1;
                plan.tag_st = CS_I;
                plan.l2     = 1'b1;
            end
            OP_DCFLUSH: begin
                plan.bus    = is_mod ? BK_WWK : (bcast ? BK_FLUSH : BK_NONE);
                plan.tag_wr = 1'b1;
                plan.tag_st = CS_I;
                plan.l2     = 1'b1;
            end
            OP_DCCLEAN: begin
                plan.bus    = is_mod ? BK_WWK : (bcast ? BK_CLEAN : BK_NONE);
                plan.tag_wr = is_mod;
                plan.tag_st = CS_E;
                plan.l2     = 1'b1;
            end
            OP_DCZERO: begin
                plan.bus    = hit ? BK_KILL : BK_WWK;
                plan.tag_wr = 1'b1;
                plan.tag_st = CS_M;
                plan.l2     = 1'b1;
            end
            OP_TOUCH, OP_TOUCHST: begin
                plan.bus    = hit ? BK_NONE : BK_RWITM;
                plan.tag_wr = !hit;
                plan.tag_st = CS_E;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cop_ctrl.sv
module cop_ctrl
    import cop_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [3:0]    op_code,
    input  logic [AW-1:0] op_addr,
    input  plan_t         plan_in,
    output logic          op_ready,
    output logic          busy,
    output logic          bus_req,
    output logic [2:0]    bus_kind,
    output logic [AW-1:0] bus_addr,
    input  logic          bus_ack,
    input  logic          memq_empty,
    input  logic          tlbsync_in,
    output logic          l2_valid,
    output logic [3:0]    l2_op,
    output logic [AW-1:0] l2_addr,
    output logic          fin_req,
    output logic [AW-1:0] fin_addr,
    output logic [1:0]    fin_state,
    input  logic          fin_grant
);
    typedef struct packed {
        phase_e        ph;
        plan_t         plan;
        logic [AW-1:0] addr;
        logic [3:0]    code;
        logic          l2v;
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic  accept;
    logic  wait_done;

    always_comb begin
        accept    = op_valid && (r_q.ph == PH_IDLE);
        wait_done = (r_q.plan.wt == WT_MEMQ) ? memq_empty :
                    (r_q.plan.wt == WT_TLB)  ? !tlbsync_in : 1'b1;
        r_d       = r_q;
        r_d.l2v   = 1'b0;
        case (r_q.ph)
            PH_IDLE: if (accept) begin
                r_d.plan = plan_in;
                r_d.addr = op_addr;
                r_d.code = op_code;
                r_d.l2v  = plan_in.l2;
                if (plan_in.bus != BK_NONE)    r_d.ph = PH_BUS;
                else if (plan_in.wt != WT_NONE) r_d.ph = PH_WAIT;
                else                            r_d.ph = PH_FIN;
            end
            PH_BUS: if (bus_ack) begin
                r_d.ph = (r_q.plan.wt != WT_NONE) ? PH_WAIT : PH_FIN;
            end
            PH_WAIT: if (wait_done) r_d.ph = PH_FIN;
            PH_FIN: if (!r_q.plan.tag_wr || fin_grant) r_d.ph = PH_IDLE;
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{ph: PH_IDLE,
                     plan: '{bus: BK_NONE, tag_wr: 1'b0, tag_st: CS_I, l2: 1'b0, wt: WT_NONE},
                     addr: '0, code: '0, l2v: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign op_ready  = (r_q.ph == PH_IDLE);
    assign busy      = (r_q.ph != PH_IDLE);
    assign bus_req   = (r_q.ph == PH_BUS);
    assign bus_kind  = r_q.plan.bus;
    assign bus_addr  = r_q.addr;
    assign l2_valid  = r_q.l2v;
    assign l2_op     = r_q.code;
    assign l2_addr   = r_q.addr;
    assign fin_req   = (r_q.ph == PH_FIN) && r_q.plan.tag_wr;
    assign fin_addr  = r_q.addr;
    assign fin_state = r_q.plan.tag_st;

    a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_kind) && $stable(bus_addr));

    a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_ready |=> busy);

    a_r11_l2_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        l2_valid |-> $past(op_valid && op_ready));

    a_r13_req_kind: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> bus_kind != BK_NONE);

    a_r9_memq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ph == PH_WAIT && r_q.plan.wt == WT_MEMQ && !memq_empty |=> busy);

    a_r10_tlb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ph == PH_WAIT && r_q.plan.wt == WT_TLB && tlbsync_in |=> busy);

    a_r7_icinv_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_ready && op_code == OP_ICINV |=> !bus_req && !l2_valid);
endmodule

// File: rtl/cop_tagarb.sv
module cop_tagarb
    import cop_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          snp_valid,
    input  logic [2:0]    snp_kind,
    input  logic [AW-1:0] snp_addr,
    input  logic          fin_req,
    input  logic [AW-1:0] fin_addr,
    input  logic [1:0]    fin_state,
    output logic          fin_grant,
    output logic          tag_wr,
    output logic [AW-1:0] tag_addr,
    output logic [1:0]    tag_state
);
    typedef struct packed {
        logic          wr;
        logic [AW-1:0] addr;
        logic [1:0]    st;
    } tw_t;

    tw_t  t_d, t_q;
    logic snp_kill;

    always_comb begin
        snp_kill  = snp_valid && (snp_kind == BK_KILL);
        fin_grant = fin_req && !snp_kill;
        t_d       = t_q;
        t_d.wr    = 1'b0;
        if (snp_kill) begin
            t_d.wr   = 1'b1;
            t_d.addr = snp_addr;
            t_d.st   = CS_I;
        end else if (fin_req) begin
            t_d.wr   = 1'b1;
            t_d.addr = fin_addr;
            t_d.st   = fin_state;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{wr: 1'b0, addr: '0, st: CS_I};
        else        t_q <= t_d;
    end

    assign tag_wr    = t_q.wr;
    assign tag_addr  = t_q.addr;
    assign tag_state = t_q.st;

    a_r12_snoop_inval: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && snp_kind == BK_KILL |=> tag_wr && tag_state == CS_I && tag_addr == $past(snp_addr));

    a_r12_nonkill_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && snp_kind != BK_KILL && !fin_req |=> !tag_wr);

    a_r12_op_deferred: assert property (@(posedge clk) disable iff (!rst_n)
        fin_req && snp_valid && snp_kind == BK_KILL |=> tag_state == CS_I);
endmodule

// File: rtl/cop_seq.sv
module cop_seq
    import cop_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    output logic          op_ready,
    input  logic [3:0]    op_code,
    input  logic [AW-1:0] op_addr,
    input  logic [1:0]    op_state,
    input  logic          bcast_en,
    output logic          busy,
    output logic          bus_req,
    output logic [2:0]    bus_kind,
    output logic [AW-1:0] bus_addr,
    input  logic          bus_ack,
    input  logic          memq_empty,
    input  logic          tlbsync_in,
    output logic          l2_valid,
    output logic [3:0]    l2_op,
    output logic [AW-1:0] l2_addr,
    output logic          tag_wr,
    output logic [AW-1:0] tag_addr,
    output logic [1:0]    tag_state,
    input  logic          snp_valid,
    input  logic [2:0]    snp_kind,
    input  logic [AW-1:0] snp_addr
);
    plan_t         plan;
    logic          fin_req;
    logic          fin_grant;
    logic [AW-1:0] fin_addr;
    logic [1:0]    fin_state;

    cop_decode u_decode (
        .code    (op_code),
        .line_st (op_state),
        .bcast   (bcast_en),
        .plan    (plan)
    );

    cop_ctrl #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_code    (op_code),
        .op_addr    (op_addr),
        .plan_in    (plan),
        .op_ready   (op_ready),
        .busy       (busy),
        .bus_req    (bus_req),
        .bus_kind   (bus_kind),
        .bus_addr   (bus_addr),
        .bus_ack    (bus_ack),
        .memq_empty (memq_empty),
        .tlbsync_in (tlbsync_in),
        .l2_valid   (l2_valid),
        .l2_op      (l2_op),
        .l2_addr    (l2_addr),
        .fin_req    (fin_req),
        .fin_addr   (fin_addr),
        .fin_state  (fin_state),
        .fin_grant  (fin_grant)
    );

    cop_tagarb #(.AW(AW)) u_tagarb (
        .clk       (clk),
        .rst_n     (rst_n),
        .snp_valid (snp_valid),
        .snp_kind  (snp_kind),
        .snp_addr  (snp_addr),
        .fin_req   (fin_req),
        .fin_addr  (fin_addr),
        .fin_state (fin_state),
        .fin_grant (fin_grant),
        .tag_wr    (tag_wr),
        .tag_addr  (tag_addr),
        .tag_state (tag_state)
    );
endmodule

// File: tb/cop_seq_tb.sv
module cop_seq_tb;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic          op_ready;
    logic [3:0]    op_code = '0;
    logic [AW-1:0] op_addr = '0;
    logic [1:0]    op_state = '0;
    logic          bcast_en = 1'b0;
    logic          busy;
    logic          bus_req;
    logic [2:0]    bus_kind;
    logic [AW-1:0] bus_addr;
    logic          bus_ack = 1'b0;
    logic          memq_empty = 1'b1;
    logic          tlbsync_in = 1'b0;
    logic          l2_valid;
    logic [3:0]    l2_op;
    logic [AW-1:0] l2_addr;
    logic          tag_wr;
    logic [AW-1:0] tag_addr;
    logic [1:0]    tag_state;
    logic          snp_valid = 1'b0;
    logic [2:0]    snp_kind = '0;
    logic [AW-1:0] snp_addr = '0;

    always #5 clk = ~clk;

    cop_seq #(.AW(AW)) u_dut (.*);

    typedef struct {
        int            val;
        logic [AW-1:0] addr;
        string         req;
    } exp_t;

    exp_t bus_q[$];
    exp_t l2_q[$];
    exp_t tag_q[$];

    int checks = 0;
    int failures = 0;
    int ack_delay = 0;
    int ack_cnt = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor and bus responder
    always @(negedge clk) begin
        exp_t e;
        if (rst_n) begin
            bus_ack = bus_req && (ack_cnt >= ack_delay);
            if (bus_req && bus_ack) begin
                ack_cnt = 0;
                if (bus_q.size() == 0) chk(0, "R3", "unexpected bus kind", bus_kind, 0);
                else begin
                    e = bus_q.pop_front();
                    chk(bus_kind == e.val[2:0] && bus_addr == e.addr, e.req, "bus kind/addr",
                        {bus_kind, bus_addr}, {e.val[2:0], e.addr});
                end
            end else if (bus_req) ack_cnt++;
            if (l2_valid) begin
                if (l2_q.size() == 0) chk(0, "R11", "unexpected l2 op", l2_op, 0);
                else begin
                    e = l2_q.pop_front();
                    chk(l2_op == e.val[3:0] && l2_addr == e.addr, e.req, "l2 op/addr",
                        {l2_op, l2_addr}, {e.val[3:0], e.addr});
                end
            end
            if (tag_wr) begin
                if (tag_q.size() == 0) chk(0, "R12", "unexpected tag write", tag_state, 0);
                else begin
                    e = tag_q.pop_front();
                    chk(tag_state == e.val[1:0] && tag_addr == e.addr, e.req, "tag state/addr",
                        {tag_state, tag_addr}, {e.val[1:0], e.addr});
                end
            end
        end
    end

    // expectation model built from the requirements
    task automatic expect_op(input int code, input logic [AW-1:0] a,
                             input int st, input bit bc, input string req);
        bit hit = (st == 1) || (st == 2);
        bit md  = (st == 2);
        case (code)
            0: if (bc) bus_q.push_back('{1, a, req});
            3: if (bc) bus_q.push_back('{2, a, req});
            5: begin
                if (bc) bus_q.push_back('{3, a, req});
                tag_q.push_back('{0, a, req});
            end
            6: begin
                if (md) bus_q.push_back('{6, a, req});
                else if (bc) bus_q.push_back('{4, a, req});
                tag_q.push_back('{0, a, req});
            end
            7: begin
                if (md) begin
                    bus_q.push_back('{6, a, req});
                    tag_q.push_back('{1, a, req});
                end else if (bc) bus_q.push_back('{5, a, req});
            end
            8: begin
                bus_q.push_back('{hit ? 3 : 6, a, req});
                tag_q.push_back('{2, a, req});
            end
            9, 10: if (!hit) begin
                bus_q.push_back('{7, a, req});
                tag_q.push_back('{1, a, req});
            end
            default: ;
        endcase
        if (code >= 5 && code <= 8) l2_q.push_back('{code, a, req});
    endtask

    task automatic start_op(input int code, input logic [AW-1:0] a,
                            input int st, input bit bc, input string req);
        expect_op(code, a, st, bc, req);
        @(negedge clk);
        while (!op_ready) @(negedge clk);
        op_valid = 1'b1;
        op_code  = code[3:0];
        op_addr  = a;
        op_state = st[1:0];
        bcast_en = bc;
        @(negedge clk);
        op_valid = 1'b0;
        chk(busy && !op_ready, "R1", "busy/ready after accept", {busy, op_ready}, 2'b10);
    endtask

    task automatic finish_op(input string req);
        while (busy) @(negedge clk);
        @(negedge clk);
        #1;
        chk(bus_q.size() == 0 && l2_q.size() == 0 && tag_q.size() == 0, req,
            "pending expectations", bus_q.size() + l2_q.size() + tag_q.size(), 0);
    endtask

    task automatic run_op(input int code, input logic [AW-1:0] a,
                          input int st, input bit bc, input string req);
        start_op(code, a, st, bc, req);
        finish_op(req);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(op_ready && !busy && !bus_req && !tag_wr && !l2_valid, "R1", "reset outputs",
            {op_ready, busy, bus_req, tag_wr, l2_valid}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 zero-block
        run_op(8, 32'h100, 1, 0, "R2");
        ack_delay = 3;
        run_op(8, 32'h140, 2, 1, "R2");
        run_op(8, 32'h180, 0, 0, "R2");
        ack_delay = 1;
        // R3/R6 invalidate
        run_op(5, 32'h200, 2, 0, "R6");
        run_op(5, 32'h240, 1, 1, "R3");
        run_op(5, 32'h280, 3, 0, "R6");
        // R4 flush
        run_op(6, 32'h300, 2, 0, "R4");
        run_op(6, 32'h340, 1, 1, "R3");
        run_op(6, 32'h380, 0, 0, "R4");
        // R5 clean
        run_op(7, 32'h400, 2, 0, "R5");
        run_op(7, 32'h440, 1, 1, "R3");
        run_op(7, 32'h480, 0, 0, "R5");
        run_op(7, 32'h4c0, 1, 0, "R11");
        // R7 quiet operations
        run_op(4, 32'h500, 2, 1, "R7");
        run_op(1, 32'h540, 0, 1, "R7");
        run_op(13, 32'h580, 2, 1, "R1");
        // R8 touch
        ack_delay = 0;
        run_op(9, 32'h600, 0, 0, "R8");
        run_op(10, 32'h640, 3, 1, "R8");
        run_op(10, 32'h680, 2, 1, "R8");
        run_op(9, 32'h6c0, 1, 0, "R8");
        // R9 barriers
        run_op(3, 32'h700, 0, 1, "R9");
        run_op(3, 32'h740, 0, 0, "R9");
        memq_empty = 1'b0;
        start_op(0, 32'h780, 0, 1, "R9");
        repeat (6) @(negedge clk);
        chk(busy, "R9", "busy while queues busy", busy, 1);
        memq_empty = 1'b1;
        finish_op("R9");
        memq_empty = 1'b0;
        start_op(0, 32'h7c0, 0, 0, "R9");
        repeat (4) @(negedge clk);
        chk(busy, "R9", "busy while queues busy, no broadcast", busy, 1);
        memq_empty = 1'b1;
        finish_op("R9");
        // R10 TLB sync
        tlbsync_in = 1'b1;
        start_op(2, 32'h800, 0, 1, "R10");
        repeat (7) @(negedge clk);
        chk(busy, "R10", "busy while tlbsync held", busy, 1);
        tlbsync_in = 1'b0;
        finish_op("R10");
        run_op(2, 32'h840, 0, 0, "R10");
        // R12 snoops while idle
        tag_q.push_back('{0, 32'h900, "R12"});
        @(negedge clk);
        snp_valid = 1'b1; snp_kind = 3'd3; snp_addr = 32'h900;
        @(negedge clk);
        snp_valid = 1'b0;
        finish_op("R12");
        @(negedge clk);
        snp_valid = 1'b1; snp_kind = 3'd4; snp_addr = 32'h940;
        @(negedge clk);
        snp_kind = 3'd6;
        @(negedge clk);
        snp_valid = 1'b0;
        finish_op("R12");
        // R12 snoop kill against op tag write
        tag_q.push_back('{0, 32'ha00, "R12"});
        tag_q.push_back('{0, 32'ha00, "R12"});
        tag_q.push_back('{0, 32'ha40, "R12"});
        l2_q.push_back('{6, 32'ha40, "R11"});
        @(negedge clk);
        op_valid = 1'b1; op_code = 4'd6; op_addr = 32'ha40; op_state = 2'd1; bcast_en = 1'b0;
        snp_valid = 1'b1; snp_kind = 3'd3; snp_addr = 32'ha00;
        @(negedge clk);
        op_valid = 1'b0;
        @(negedge clk);
        snp_valid = 1'b0;
        chk(busy, "R12", "op held behind snoop", busy, 1);
        finish_op("R12");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule